// File: doc/BRIEF.md
# Wide Register File Coprocessor Datapath

This block is the execution datapath of a wide-word coprocessor. It holds a bank of thirty-two 128-bit registers and services two independent operation slots every cycle. The memory slot moves a whole 128-bit register to or from a local data memory. Its address is a 32-bit base value plus an 8-bit signed displacement. The arithmetic slot combines two registers with a full-width add, a bitwise AND or a bitwise OR, and writes the result to a third register.

Both slots may issue in the same cycle. The register bank has three read ports and two write ports. Two read ports serve the ALU operands and one serves the store data. One write port takes the ALU result and the other takes returning load data. Memory requests are combinational from the issued operation. Load data comes back exactly one cycle after the request and is written at the end of that cycle. Register reads never see a write that lands at the same clock edge.

Top module: `wide_vec_dp`

## Requirements
- R1: After reset every register reads as zero, and while `ls_valid` is low both `mem_we` and `mem_re` are low.
- R2: While `ls_valid` is high, `mem_addr` equals `ls_base` plus `ls_disp` sign-extended to 32 bits, modulo 2^32 (displacements -128 to +127).
- R3: A store (`ls_valid` high, `ls_store` high) raises `mem_we` in the same cycle, keeps `mem_re` low, drives register `ls_reg` onto `mem_wdata`, and changes no register.
- R4: A load (`ls_valid` high, `ls_store` low) raises `mem_re` in the same cycle. The value on `mem_rdata` in the following cycle is written into register `ls_reg` at the end of that cycle. `mem_rdata` is ignored in every other cycle.
- R5: `alu_op` = 0 writes the 128-bit sum of registers `alu_src_a` and `alu_src_b` into `alu_dst`, and the carry-out is discarded.
- R6: `alu_op` = 1 writes the bitwise AND of the two source registers, and `alu_op` = 2 writes the bitwise OR.
- R7: An ALU result is written at the end of its issue cycle. Any read in that cycle, including a store of the destination, sees the old value.
- R8: A load return and an ALU operation to different registers in the same cycle both take effect.
- R9: When a load return and an ALU result target the same register in the same cycle, the load data is kept.
- R10: With `alu_valid` low, or with `alu_op` = 3, the ALU slot changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_valid | input | 1 | Memory slot issues an operation this cycle |
| ls_store | input | 1 | 1 = store, 0 = load |
| ls_base | input | 32 | Base address |
| ls_disp | input | 8 | Signed displacement |
| ls_reg | input | 5 | Load destination / store source register |
| alu_valid | input | 1 | ALU slot issues an operation this cycle |
| alu_op | input | 2 | 0 add, 1 AND, 2 OR, 3 no write |
| alu_src_a | input | 5 | First source register |
| alu_src_b | input | 5 | Second source register |
| alu_dst | input | 5 | Destination register |
| mem_addr | output | 32 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read request |
| mem_wdata | output | 128 | Store data |
| mem_rdata | input | 128 | Load data, valid one cycle after `mem_re` |

## Verification
The memory request outputs are due in the issue cycle itself. The bench drives each operation at the falling edge and compares `mem_we`, `mem_re`, `mem_addr` and `mem_wdata` one nanosecond later, before the next rising edge. An ALU result becomes visible through a store issued one cycle later. Load data is supplied by the bench in the cycle after the request and can be stored out two cycles after the request. The reference model therefore commits the ALU write, then the load write, at each rising edge, so that a same-cycle collision resolves in favour of the load. A store in the cycle of a pending write is compared against the value held before that write.

// File: rtl/wide_vec_dp_pkg.sv
package wide_vec_dp_pkg;

    typedef enum logic [1:0] {
        WOP_ADD  = 2'd0,
        WOP_AND  = 2'd1,
        WOP_OR   = 2'd2,
        WOP_NONE = 2'd3
    } wop_e;

    localparam int NUM_RD_PORTS = 3;
    localparam int RD_ALU_A     = 0;
    localparam int RD_ALU_B     = 1;
    localparam int RD_STORE     = 2;

endpackage

// File: rtl/wide_vec_dp_agu.sv
module wide_vec_dp_agu #(
    parameter int AW   = 32,
    parameter int OFFW = 8
) (
    input  logic [AW-1:0]   base_i,
    input  logic [OFFW-1:0] disp_i,
    output logic [AW-1:0]   addr_o
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXTW{disp_i[OFFW-1]}}, disp_i};
        addr_o   = base_i + disp_ext;
    end
endmodule

// File: rtl/wide_vec_dp_alu.sv
module wide_vec_dp_alu
    import wide_vec_dp_pkg::*;
#(
    parameter int W = 128
) (
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         wen_o
);
    wop_e op;

    always_comb begin
        op    = wop_e'(op_i);
        res_o = '0;
        wen_o = 1'b0;
        unique case (op)
            WOP_ADD: begin
                res_o = a_i + b_i;
                wen_o = valid_i;
            end
            WOP_AND: begin
                res_o = a_i & b_i;
                wen_o = valid_i;
            end
            WOP_OR: begin
                res_o = a_i | b_i;
                wen_o = valid_i;
            end
            default: begin
                res_o = '0;
                wen_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wide_vec_dp_rdport.sv
module wide_vec_dp_rdport #(
    parameter int W    = 128,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][W-1:0] bank_i,
    input  logic [RW-1:0]          sel_i,
    output logic [W-1:0]           data_o
);
    always_comb begin
        data_o = bank_i[sel_i];
    end
endmodule

// File: rtl/wide_vec_dp.sv
module wide_vec_dp
    import wide_vec_dp_pkg::*;
#(
    parameter int W    = 128,
    parameter int NREG = 32,
    parameter int AW   = 32,
    parameter int OFFW = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ls_valid,
    input  logic          ls_store,
    input  logic [AW-1:0] ls_base,
    input  logic [OFFW-1:0] ls_disp,
    input  logic [RW-1:0] ls_reg,
    input  logic          alu_valid,
    input  logic [1:0]    alu_op,
    input  logic [RW-1:0] alu_src_a,
    input  logic [RW-1:0] alu_src_b,
    input  logic [RW-1:0] alu_dst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] bank;
        logic                   ld_pend;
        logic [RW-1:0]          ld_reg;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic [NREG-1:0][W-1:0]         bank_view;
    logic [NUM_RD_PORTS-1:0][RW-1:0] rd_sel;
    logic [NUM_RD_PORTS-1:0][W-1:0]  rd_data;
    logic [W-1:0]                   alu_res;
    logic                           alu_wen;
    logic                           ld_pend_q;
    logic [RW-1:0]                  ld_reg_q;

    assign bank_view = st_q.bank;
    assign ld_pend_q = st_q.ld_pend;
    assign ld_reg_q  = st_q.ld_reg;

    always_comb begin
        rd_sel[RD_ALU_A] = alu_src_a;
        rd_sel[RD_ALU_B] = alu_src_b;
        rd_sel[RD_STORE] = ls_reg;
    end

    for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
        wide_vec_dp_rdport #(
            .W    (W),
            .NREG (NREG)
        ) u_rd (
            .bank_i (bank_view),
            .sel_i  (rd_sel[p]),
            .data_o (rd_data[p])
        );
    end

    wide_vec_dp_agu #(
        .AW   (AW),
        .OFFW (OFFW)
    ) u_agu (
        .base_i (ls_base),
        .disp_i (ls_disp),
        .addr_o (mem_addr)
    );

    wide_vec_dp_alu #(
        .W (W)
    ) u_alu (
        .valid_i (alu_valid),
        .op_i    (alu_op),
        .a_i     (rd_data[RD_ALU_A]),
        .b_i     (rd_data[RD_ALU_B]),
        .res_o   (alu_res),
        .wen_o   (alu_wen)
    );

    always_comb begin
        mem_we    = ls_valid & ls_store;
        mem_re    = ls_valid & ~ls_store;
        mem_wdata = rd_data[RD_STORE];
    end

    always_comb begin
        st_d = st_q;
        if (alu_wen) begin
            st_d.bank[alu_dst] = alu_res;
        end
        // load return is applied last so it overrides an ALU write to the same entry
        if (st_q.ld_pend) begin
            st_d.bank[st_q.ld_reg] = mem_rdata;
        end
        st_d.ld_pend = ls_valid & ~ls_store;
        st_d.ld_reg  = ls_reg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wide_vec_dp_chk.sv
module wide_vec_dp_chk #(
    parameter int W    = 128,
    parameter int NREG = 32,
    parameter int AW   = 32,
    parameter int OFFW = 8,
    localparam int RW  = $clog2(NREG)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ls_valid,
    input logic                   ls_store,
    input logic [AW-1:0]          ls_base,
    input logic [OFFW-1:0]        ls_disp,
    input logic                   alu_valid,
    input logic [1:0]             alu_op,
    input logic [RW-1:0]          alu_src_a,
    input logic [RW-1:0]          alu_src_b,
    input logic [RW-1:0]          alu_dst,
    input logic [AW-1:0]          mem_addr,
    input logic                   mem_we,
    input logic                   mem_re,
    input logic [W-1:0]           mem_rdata,
    input logic [NREG-1:0][W-1:0] bank,
    input logic                   ld_pend,
    input logic [RW-1:0]          ld_reg
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_valid |-> (!mem_we && !mem_re));

    // R2
    addr_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_valid |-> ((mem_addr - ls_base) == AW'($signed(ls_disp))));

    // R3
    store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_valid && ls_store) |-> (mem_we && !mem_re));

    // R3
    store_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ld_pend && !(alu_valid && alu_op != 2'd3)) |=> $stable(bank));

    // R4
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pend |=> (bank[$past(ld_reg)] == $past(mem_rdata)));

    // R5
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 2'd0 && !(ld_pend && ld_reg == alu_dst))
        |=> (bank[$past(alu_dst)] == W'($past(bank[alu_src_a]) + $past(bank[alu_src_b]))));

    // R6
    and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 2'd1 && !(ld_pend && ld_reg == alu_dst))
        |=> (bank[$past(alu_dst)] == ($past(bank[alu_src_a]) & $past(bank[alu_src_b]))));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pend && alu_valid && alu_op != 2'd3 && alu_dst == ld_reg)
        |=> (bank[$past(alu_dst)] == $past(mem_rdata)));

    // R10
    alu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_pend && !(alu_valid && alu_op != 2'd3)) |=> $stable(bank));
endmodule

bind wide_vec_dp wide_vec_dp_chk #(
    .W    (W),
    .NREG (NREG),
    .AW   (AW),
    .OFFW (OFFW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ls_valid  (ls_valid),
    .ls_store  (ls_store),
    .ls_base   (ls_base),
    .ls_disp   (ls_disp),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .alu_src_a (alu_src_a),
    .alu_src_b (alu_src_b),
    .alu_dst   (alu_dst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_rdata (mem_rdata),
    .bank      (bank_view),
    .ld_pend   (ld_pend_q),
    .ld_reg    (ld_reg_q)
);

// File: tb/wide_vec_dp_bench.sv
`timescale 1ns/1ps
module wide_vec_dp_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ls_valid = 1'b0;
    logic         ls_store = 1'b0;
    logic [31:0]  ls_base = '0;
    logic [7:0]   ls_disp = '0;
    logic [4:0]   ls_reg = '0;
    logic         alu_valid = 1'b0;
    logic [1:0]   alu_op = '0;
    logic [4:0]   alu_src_a = '0;
    logic [4:0]   alu_src_b = '0;
    logic [4:0]   alu_dst = '0;
    logic [31:0]  mem_addr;
    logic         mem_we;
    logic         mem_re;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [127:0] model [32];
    logic         m_pend = 1'b0;
    logic [4:0]   m_pend_reg = '0;
    logic [127:0] m_pend_data = '0;

    localparam logic [127:0] ONES = {128{1'b1}};
    localparam logic [127:0] PAT_A = 128'hF0F0_1234_0000_FFFF_A5A5_5A5A_8000_0001;
    localparam logic [127:0] PAT_B = 128'h0FF0_4321_FFFF_00FF_3C3C_C3C3_7FFF_FFFF;
    localparam logic [127:0] JUNK = {4{32'hBAD0_F00D}};

    always #2.5 clk = ~clk;

    wide_vec_dp u_wide_vec_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ls_valid  (ls_valid),
        .ls_store  (ls_store),
        .ls_base   (ls_base),
        .ls_disp   (ls_disp),
        .ls_reg    (ls_reg),
        .alu_valid (alu_valid),
        .alu_op    (alu_op),
        .alu_src_a (alu_src_a),
        .alu_src_b (alu_src_b),
        .alu_dst   (alu_dst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic lsv, input logic st, input logic [31:0] base,
                        input logic [7:0] disp, input logic [4:0] lreg,
                        input logic [127:0] ldata, input logic av, input logic [1:0] op,
                        input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] rd,
                        input string tag);
        logic [31:0]  ea;
        logic [127:0] res;
        string        stag;
        @(negedge clk);
        ls_valid = lsv; ls_store = st; ls_base = base; ls_disp = disp; ls_reg = lreg;
        alu_valid = av; alu_op = op; alu_src_a = ra; alu_src_b = rb; alu_dst = rd;
        mem_rdata = m_pend ? m_pend_data : JUNK;
        #1;
        stag = lsv ? tag : "R1";
        check(mem_we === (lsv & st), lsv ? "R3" : "R1", "mem_we", 128'(mem_we), 128'(lsv & st));
        check(mem_re === (lsv & ~st), lsv ? "R4" : "R1", "mem_re", 128'(mem_re), 128'(lsv & ~st));
        if (lsv) begin
            ea = base + {{24{disp[7]}}, disp};
            check(mem_addr === ea, "R2", "mem_addr", 128'(mem_addr), 128'(ea));
        end
        if (lsv && st) begin
            check(mem_wdata === model[lreg], stag, "mem_wdata", mem_wdata, model[lreg]);
        end
        @(posedge clk);
        case (op)
            2'd0:    res = model[ra] + model[rb];
            2'd1:    res = model[ra] & model[rb];
            default: res = model[ra] | model[rb];
        endcase
        if (av && op != 2'd3) model[rd] = res;
        if (m_pend) model[m_pend_reg] = m_pend_data;
        m_pend      = lsv & ~st;
        m_pend_reg  = lreg;
        m_pend_data = ldata;
    endtask

    task automatic idle();
        step(0, 0, 32'h0, 8'h0, 5'd0, '0, 0, 2'd0, 5'd0, 5'd0, 5'd0, "R10");
    endtask

    task automatic ld(input logic [4:0] r, input logic [31:0] base, input logic [7:0] d,
                      input logic [127:0] data, input string tag);
        step(1, 0, base, d, r, data, 0, 2'd0, 5'd0, 5'd0, 5'd0, tag);
    endtask

    task automatic sto(input logic [4:0] r, input string tag);
        step(1, 1, 32'h0000_2000, 8'h10, r, '0, 0, 2'd0, 5'd0, 5'd0, 5'd0, tag);
    endtask

    task automatic alu(input logic [1:0] op, input logic [4:0] rd, input logic [4:0] ra,
                       input logic [4:0] rb, input string tag);
        step(0, 0, 32'h0, 8'h0, 5'd0, '0, 1, op, ra, rb, rd, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(mem_we === 1'b0 && mem_re === 1'b0, "R1", "strobes in reset",
              128'({mem_we, mem_re}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i++) sto(5'(i), "R1");

        // R2/R4: loads with negative, positive and wrapping displacements
        ld(5'd1, 32'h0000_1000, 8'h80, ONES, "R4");
        ld(5'd2, 32'h0000_1000, 8'h7F, 128'd1, "R4");
        ld(5'd3, 32'hFFFF_FFF0, 8'h7F, PAT_A, "R4");
        ld(5'd4, 32'h0000_0005, 8'hF0, PAT_B, "R4");
        idle();
        sto(5'd1, "R4"); sto(5'd2, "R4"); sto(5'd3, "R4"); sto(5'd4, "R4");

        // R5: full-width add, carry dropped
        alu(2'd0, 5'd5, 5'd1, 5'd2, "R5");
        sto(5'd5, "R5");
        alu(2'd0, 5'd6, 5'd3, 5'd4, "R5");
        sto(5'd6, "R5");

        // R6: AND and OR
        alu(2'd1, 5'd7, 5'd3, 5'd4, "R6");
        alu(2'd2, 5'd8, 5'd3, 5'd4, "R6");
        sto(5'd7, "R6"); sto(5'd8, "R6");

        // R7: store of the ALU destination in the same cycle sees the old value
        step(1, 1, 32'h100, 8'h00, 5'd9, '0, 1, 2'd2, 5'd3, 5'd1, 5'd9, "R7");
        sto(5'd9, "R7");

        // R4: store during the load return cycle sees the old value
        ld(5'd10, 32'h40, 8'h04, PAT_B, "R4");
        sto(5'd10, "R4");
        sto(5'd10, "R4");

        // R8: load return and ALU write to different registers together
        ld(5'd11, 32'h80, 8'hFF, PAT_A, "R8");
        alu(2'd1, 5'd12, 5'd1, 5'd4, "R8");
        sto(5'd11, "R8"); sto(5'd12, "R8");

        // R8: load issue together with an ALU op in the same cycle
        step(1, 0, 32'h200, 8'h08, 5'd13, ONES, 1, 2'd0, 5'd2, 5'd2, 5'd14, "R8");
        idle();
        sto(5'd13, "R8"); sto(5'd14, "R8");

        // R9: collision on the same register, load data kept
        ld(5'd15, 32'h300, 8'h00, PAT_A, "R9");
        alu(2'd2, 5'd15, 5'd4, 5'd1, "R9");
        sto(5'd15, "R9");

        // R9: collision while the ALU reads the pending register
        ld(5'd16, 32'h310, 8'h01, PAT_B, "R9");
        alu(2'd0, 5'd16, 5'd16, 5'd2, "R9");
        sto(5'd16, "R9");

        // R10: op 3 and alu_valid low write nothing
        alu(2'd3, 5'd3, 5'd1, 5'd1, "R10");
        step(0, 0, 32'h0, 8'h0, 5'd0, '0, 0, 2'd0, 5'd1, 5'd1, 5'd4, "R10");
        sto(5'd3, "R10"); sto(5'd4, "R10");

        // R4: back-to-back loads to the same and different registers
        ld(5'd17, 32'h400, 8'h00, PAT_A, "R4");
        ld(5'd17, 32'h410, 8'h00, PAT_B, "R4");
        ld(5'd18, 32'h420, 8'h00, ONES, "R4");
        idle();
        sto(5'd17, "R4"); sto(5'd18, "R4");
        idle();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule